// File: doc/BRIEF.md
# Two-Lane Interleaving Uplink Serializer

This block merges two serial readout lanes into one uplink that runs at twice the per-lane bit rate. Each lane carries data from a chain of eight readout chips that are read out in turn by a token passed along the chain. A single fast clock paces the uplink slots, and every second cycle marks a lane bit boundary. On that boundary the block takes one bit from each lane. It then sends the lane A bit, followed by the complement of the lane B bit. Because lane B is inverted, an idle or slowly varying link still toggles, so the line stays near DC balance without a line code.

A readout trigger sends a start token down both chains in the same cycle. Each lane counts as busy from that token until its chain hands the token back. While a lane is not busy, its input is replaced by the idle value 0, so a fully idle link sends 0,1,0,1 on the uplink. A trigger that arrives while either lane is still busy is dropped. The lane source uses the bit-enable output to line its bits up with the boundaries.

Top module: `ilv_uplink_mux`

## Requirements
- R1: While reset is high, at the following falling edge `uplink_o` is 1, `slot_o` is 1, `busy_o` is 2'b00, and both token outputs are 0.
- R2: After reset, `slot_o` reads 0 (lane A slot) for the first uplink bit and then toggles every cycle. `bit_en_o` is 1 exactly in the cycles in which `slot_o` is 1, and the lane inputs are sampled at the rising edge that ends such a cycle.
- R3: An uplink bit with `slot_o`=0 equals the `chan_a_i` value sampled at the preceding boundary edge, provided `busy_o[0]` was 1 at that edge.
- R4: An uplink bit with `slot_o`=1 equals the complement of the `chan_b_i` value sampled at the boundary edge one cycle earlier, provided `busy_o[1]` was 1 at that edge.
- R5: A lane that is not busy at a boundary edge contributes the idle bit 0 in place of its input, so that lane's slot shows 0 for lane A and 1 for lane B.
- R6: A trigger accepted at an edge raises `tok_out_a_o` and `tok_out_b_o` together for exactly one cycle and sets `busy_o` to 2'b11 at that same edge.
- R7: A trigger seen while `busy_o` is not 2'b00 is ignored: no token pulse appears and `busy_o` is unchanged.
- R8: A token return on one lane (`tok_ret_a_i` clears bit 0, `tok_ret_b_i` clears bit 1) clears only that lane's busy flag at the next edge. A trigger is accepted again in the cycle after the last lane returns.
- R9: A token return on a lane that is not busy has no effect on `busy_o` or on the uplink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Uplink slot clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Readout trigger, starts both token chains |
| chan_a_i | input | 1 | Serial bit of lane A, held for two cycles |
| chan_b_i | input | 1 | Serial bit of lane B, held for two cycles |
| tok_ret_a_i | input | 1 | Token returned from the end of chain A |
| tok_ret_b_i | input | 1 | Token returned from the end of chain B |
| tok_out_a_o | output | 1 | One-cycle start token into chain A |
| tok_out_b_o | output | 1 | One-cycle start token into chain B |
| busy_o | output | 2 | Busy flag per lane, bit 0 lane A, bit 1 lane B |
| bit_en_o | output | 1 | High in the cycle before a lane bit boundary |
| slot_o | output | 1 | Lane of the current uplink bit, 0 for A and 1 for B |
| uplink_o | output | 1 | Merged serial uplink bit |

## Verification
A phase counter that slips swaps the lanes on the uplink. The next slot then carries the wrong polarity, and an idle link shows 1,0 where 0,1 is expected, so the error appears within two cycles. A busy flag that is stuck or cleared too early shows up at the very next boundary. Either real data is replaced by the idle value or idle data leaks through. It also shows on the token outputs when a second trigger is accepted or rejected wrongly. A lost or duplicated held B bit shows up one slot after its A partner.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned NCH      = 2;
    localparam logic        IDLE_BIT = 1'b0;

    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

    typedef struct packed {
        logic b;
        logic a;
    } lane_pair_t;

    function automatic lane_pair_t idle_mask(lane_pair_t raw, logic [NCH-1:0] busy);
        lane_pair_t m;
        m.a = busy[0] ? raw.a : IDLE_BIT;
        m.b = busy[1] ? raw.b : IDLE_BIT;
        return m;
    endfunction

endpackage

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen
    import ilv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    output slot_e phase_o,
    output logic  bit_en_o
);
    slot_e ph_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) ph_q <= SLOT_A;
        else       ph_q <= (ph_q == SLOT_A) ? SLOT_B : SLOT_A;
    end

    assign phase_o  = ph_q;
    assign bit_en_o = (ph_q == SLOT_A);
endmodule

// File: rtl/ilv_token_ctl.sv
module ilv_token_ctl (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic ret_i,
    output logic tok_o,
    output logic busy_o
);
    logic busy_q;
    logic tok_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            tok_q  <= 1'b0;
        end else begin
            tok_q <= start_i;
            if (start_i)              busy_q <= 1'b1;
            else if (ret_i && busy_q) busy_q <= 1'b0;
        end
    end

    assign tok_o  = tok_q;
    assign busy_o = busy_q;
endmodule

// File: rtl/ilv_lane_merge.sv
module ilv_lane_merge
    import ilv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  slot_e      phase_i,
    input  lane_pair_t bits_i,
    output logic       uplink_o,
    output slot_e      slot_o
);
    logic  up_q;
    logic  held_b_q;
    slot_e slot_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            up_q     <= 1'b1;
            held_b_q <= IDLE_BIT;
            slot_q   <= SLOT_B;
        end else begin
            slot_q <= phase_i;
            if (phase_i == SLOT_A) begin
                up_q     <= bits_i.a;
                held_b_q <= bits_i.b;
            end else begin
                up_q <= ~held_b_q;
            end
        end
    end

    assign uplink_o = up_q;
    assign slot_o   = slot_q;
endmodule

// File: rtl/ilv_uplink_mux.sv
module ilv_uplink_mux
    import ilv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       trig_i,
    input  logic       chan_a_i,
    input  logic       chan_b_i,
    input  logic       tok_ret_a_i,
    input  logic       tok_ret_b_i,
    output logic       tok_out_a_o,
    output logic       tok_out_b_o,
    output logic [1:0] busy_o,
    output logic       bit_en_o,
    output logic       slot_o,
    output logic       uplink_o
);
    slot_e           phase;
    slot_e           slot;
    logic [NCH-1:0]  busy;
    logic [NCH-1:0]  tok;
    logic [NCH-1:0]  ret;
    logic            start;
    lane_pair_t      raw_bits;
    lane_pair_t      eff_bits;

    assign ret      = {tok_ret_b_i, tok_ret_a_i};
    assign start    = trig_i && (busy == '0);
    assign raw_bits = '{b: chan_b_i, a: chan_a_i};
    assign eff_bits = idle_mask(raw_bits, busy);

    ilv_phase_gen u_phase (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .phase_o  (phase),
        .bit_en_o (bit_en_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        ilv_token_ctl u_tok (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .start_i (start),
            .ret_i   (ret[c]),
            .tok_o   (tok[c]),
            .busy_o  (busy[c])
        );
    end

    ilv_lane_merge u_merge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .phase_i  (phase),
        .bits_i   (eff_bits),
        .uplink_o (uplink_o),
        .slot_o   (slot)
    );

    assign tok_out_a_o = tok[0];
    assign tok_out_b_o = tok[1];
    assign busy_o      = busy;
    assign slot_o      = slot;
endmodule

// File: rtl/ilv_uplink_chk.sv
module ilv_uplink_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       trig_i,
    input logic       tok_ret_a_i,
    input logic       tok_out_a_o,
    input logic       tok_out_b_o,
    input logic [1:0] busy_o,
    input logic       bit_en_o,
    input logic       slot_o
);
    a_r2_slot_toggles: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> slot_o != $past(slot_o));

    a_r2_enable_phase: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_en_o |=> !bit_en_o);

    a_r6_tokens_paired: assert property (@(posedge clk_i) disable iff (rst_i)
        tok_out_a_o == tok_out_b_o);

    a_r6_token_sets_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        tok_out_a_o |-> busy_o == 2'b11);

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        tok_out_a_o |=> !tok_out_a_o);

    a_r7_no_token_when_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o != 2'b00) |=> !tok_out_a_o);

    a_r8_return_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (tok_ret_a_i && busy_o[0]) |=> !busy_o[0]);

    a_r9_idle_return: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o[0] && !trig_i) |=> !busy_o[0]);
endmodule

bind ilv_uplink_mux ilv_uplink_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .trig_i      (trig_i),
    .tok_ret_a_i (tok_ret_a_i),
    .tok_out_a_o (tok_out_a_o),
    .tok_out_b_o (tok_out_b_o),
    .busy_o      (busy_o),
    .bit_en_o    (bit_en_o),
    .slot_o      (slot_o)
);

// File: tb/ilv_uplink_mux_tb_top.sv
`timescale 1ns/1ps
module ilv_uplink_mux_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0, ch_a = 1'b0, ch_b = 1'b0, ret_a = 1'b0, ret_b = 1'b0;
    logic tok_a, tok_b, bit_en, slot, uplink;
    logic [1:0] busy;

    ilv_uplink_mux dut_i (
        .clk_i(clk), .rst_i(rst), .trig_i(trig),
        .chan_a_i(ch_a), .chan_b_i(ch_b),
        .tok_ret_a_i(ret_a), .tok_ret_b_i(ret_b),
        .tok_out_a_o(tok_a), .tok_out_b_o(tok_b),
        .busy_o(busy), .bit_en_o(bit_en), .slot_o(slot), .uplink_o(uplink)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    // queue entry: {tag, value}; tag 3=R3, 4=R4, 5=R5
    logic [3:0] exp_q[$];
    logic mba = 1'b0, mbb = 1'b0, exp_tok = 1'b0, exp_slot = 1'b0;
    bit   mon_on = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(bit t, bit ia, bit ib);
        bit acc;
        exp_slot = bit_en ? 1'b0 : 1'b1;
        if (bit_en) begin
            ch_a = 1'($urandom);
            ch_b = 1'($urandom);
            // R3 / R5: lane A slot, idle bit 0 when not busy
            exp_q.push_back({mba ? 3'd3 : 3'd5, mba ? ch_a : 1'b0});
            // R4 / R5: lane B slot, inverted
            exp_q.push_back({mbb ? 3'd4 : 3'd5, ~(mbb ? ch_b : 1'b0)});
        end
        trig = t; ret_a = ia; ret_b = ib;
        acc = t && !mba && !mbb;
        exp_tok = acc;
        if (acc) begin
            mba = 1'b1; mbb = 1'b1;
        end else begin
            if (ia) mba = 1'b0;
            if (ib) mbb = 1'b0;
        end
    endtask

    task automatic step(bit t, bit ia, bit ib);
        @(negedge clk);
        if (mon_on) begin
            chk(slot == exp_slot, "R2", "slot", slot, exp_slot);
            chk(bit_en == slot, "R2", "bit_en", bit_en, slot);
            chk(tok_a == exp_tok, exp_tok ? "R6" : "R7", "tok_a", tok_a, exp_tok);
            chk(tok_b == exp_tok, exp_tok ? "R6" : "R7", "tok_b", tok_b, exp_tok);
            chk(busy == {mbb, mba}, "R8", "busy", busy, {mbb, mba});
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                e = exp_q.pop_front();
                if (e[3:1] == 3'd3)      chk(uplink == e[0], "R3", "uplink A", uplink, e[0]);
                else if (e[3:1] == 3'd4) chk(uplink == e[0], "R4", "uplink B", uplink, e[0]);
                else                     chk(uplink == e[0], "R5", "uplink idle", uplink, e[0]);
            end
        end
        drive(t, ia, ib);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(uplink == 1'b1, "R1", "uplink", uplink, 1);
        chk(slot == 1'b1, "R1", "slot", slot, 1);
        chk(busy == 2'b00, "R1", "busy", busy, 0);
        chk(tok_a == 1'b0 && tok_b == 1'b0, "R1", "tokens", {tok_b, tok_a}, 0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0);
        mon_on = 1'b1;
        run(20);                         // R5 idle pattern
        step(1'b0, 1'b1, 1'b0);          // R9 return while idle
        run(4);
        step(1'b1, 1'b0, 1'b0);          // R6 trigger accepted
        run(30);                         // R3 R4 data
        step(1'b1, 1'b0, 1'b0);          // R7 trigger while busy
        run(5);
        step(1'b0, 1'b1, 1'b0);          // R8 lane A returns
        run(9);
        step(1'b1, 1'b0, 1'b0);          // R7 B still busy
        run(6);
        step(1'b0, 1'b0, 1'b1);          // R8 lane B returns
        step(1'b1, 1'b0, 1'b0);          // R8 back-to-back trigger accepted
        run(11);
        step(1'b0, 1'b0, 1'b1);          // B first this time
        step(1'b1, 1'b0, 1'b0);          // R7 ignored
        run(3);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);          // R6 accepted again on odd phase
        run(8);
        step(1'b0, 1'b1, 1'b1);          // both return together
        run(12);
        step(1'b0, 1'b0, 1'b1);          // R9 return on idle lane B
        run(6);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule